// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns parallel characters into an asynchronous serial stream. A 7-bit line-control word sets the frame: 5 to 8 data bits, an optional parity slot that is computed or forced to a fixed value, and a stop interval of one, one and a half or two bit times. Timing comes from a one-cycle strobe that an external baud generator raises 16 times per bit. Characters come from an upstream FIFO over a valid/ready handshake.

The line control also holds a break request, which pulls the line low while the framer is idle. Two side inputs complete the block: a transmit disable that blocks new characters, and an output inversion for links with inverted polarity. The frame format is captured when a character is accepted. Changing the control word during a frame, or asserting break or disable then, takes effect only after the current stop interval has been sent.

Top module: `uart_tx_framer`

## Requirements
- R1: While idle and not in break, the line (txd XOR tx_invert) is high, busy is low, and in_ready is high unless tx_disable is set.
- R2: A character is accepted on a clock edge with in_valid and in_ready both high. The frame is a low start bit followed by the data bits, least significant first. Each of these bits lasts 16 tick strobes.
- R3: ctrl[1:0] sets the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the word length are not sent.
- R4: With ctrl[2] clear the stop interval is 16 ticks of high line. With ctrl[2] set it is 24 ticks for 5-bit words and 32 ticks for other lengths. busy falls on the tick that ends the stop interval.
- R5: ctrl[3] adds a parity bit after the data bits. With ctrl[4]=1 it makes the count of ones in data plus parity even; with ctrl[4]=0 it makes that count odd.
- R6: When ctrl[5] is set, the parity slot is sent whatever ctrl[3] holds, and it carries the value of ctrl[4] (1 marks an address character).
- R7: While ctrl[6] is set and no frame is in progress, the line is low and in_ready is low. A frame in progress when ctrl[6] rises is completed first.
- R8: While tx_disable is set, in_ready is low and no frame starts. A frame in progress is completed.
- R9: tx_invert inverts txd in every state, idle included.
- R10: The format is taken from ctrl at the moment of acceptance. Changes to ctrl during the frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversample strobe, 16 per bit time |
| ctrl | input | 7 | Line control: [1:0] length, [2] long stop, [3] parity enable, [4] even / forced value, [5] force parity, [6] break |
| tx_disable | input | 1 | Blocks new characters |
| tx_invert | input | 1 | Inverts the serial output |
| in_valid | input | 1 | Character offered by the FIFO |
| in_data | input | 8 | Character, LSB sent first |
| in_ready | output | 1 | Framer takes the character this cycle |
| txd | output | 1 | Serial output |
| busy | output | 1 | A frame is in progress |

## Verification
The break request and the handshake can reach the framer in the same cycle. The bench raises ctrl[6] on the same clock edge that it offers a character to an idle framer. The run passes only if the character is refused, the line goes low, and in_ready stays low until break is released. A second case raises break while a frame is being sent and keeps a character waiting. Every remaining bit of that frame must still come out at its expected tick, and at the tick the stop interval ends the line must drop into break and the waiting character must not be taken.

// File: rtl/uart_tx_framer.sv
module uart_tx_framer #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [6:0] ctrl,
  input  logic       tx_disable,
  input  logic       tx_invert,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       txd,
  output logic       busy
);
  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] T_ONE  = CW'(OVS - 1);
  localparam logic [CW-1:0] T_HALF = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] T_TWO  = CW'(2 * OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx, last;
  logic [7:0]    sh;
  logic          par_on, par_bit, stop_half, stop_two;
  logic [7:0]    mask;
  logic [CW-1:0] span;
  logic          bit_end, take, raw;

  assign mask     = 8'hFF >> (2'd3 - ctrl[1:0]);
  assign in_ready = (st == S_IDLE) && !tx_disable && !ctrl[6];
  assign take     = in_valid && in_ready;
  assign busy     = (st != S_IDLE);

  assign span    = (st != S_STOP) ? T_ONE : stop_two ? T_TWO : stop_half ? T_HALF : T_ONE;
  assign bit_end = tick && (cnt == span);

  always_comb begin
    case (st)
      S_IDLE:  raw = !ctrl[6];
      S_START: raw = 1'b0;
      S_DATA:  raw = sh[0];
      S_PAR:   raw = par_bit;
      default: raw = 1'b1;
    endcase
  end

  assign txd = raw ^ tx_invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      idx       <= '0;
      last      <= '0;
      sh        <= '0;
      par_on    <= 1'b0;
      par_bit   <= 1'b0;
      stop_half <= 1'b0;
      stop_two  <= 1'b0;
    end else if (st == S_IDLE) begin
      cnt <= '0;
      idx <= '0;
      if (take) begin
        st        <= S_START;
        sh        <= in_data;
        last      <= 3'd4 + {1'b0, ctrl[1:0]};
        par_on    <= ctrl[3] | ctrl[5];
        par_bit   <= ctrl[5] ? ctrl[4] : (^(in_data & mask)) ^ ~ctrl[4];
        stop_half <= ctrl[2] && (ctrl[1:0] == 2'd0);
        stop_two  <= ctrl[2] && (ctrl[1:0] != 2'd0);
      end
    end else if (tick) begin
      cnt <= bit_end ? '0 : cnt + 1'b1;
      if (bit_end) begin
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            sh  <= sh >> 1;
            idx <= idx + 1'b1;
            if (idx == last) st <= par_on ? S_PAR : S_STOP;
          end
          S_PAR:   st <= S_STOP;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [6:0] ctrl,
  input logic       tx_disable,
  input logic       tx_invert,
  input logic       in_valid,
  input logic       in_ready,
  input logic       txd,
  input logic       busy
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctrl[6]) |-> (txd ^ tx_invert));

  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !(txd ^ tx_invert)));

  assert_no_end_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);

  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl[6]) |-> (!(txd ^ tx_invert) && !in_ready));

  assert_disable_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_disable |-> !in_ready);

  assert_ready_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (.*);

// File: tb/sim_uart_tx_framer.sv
`timescale 1ns/1ps
module sim_uart_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] ctrl = '0;
  logic       tx_disable = 1'b0;
  logic       tx_invert = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, txd, busy;

  int errors = 0;
  int checks = 0;
  int tick_count = 0;
  int div = 0;

  always #2.5 clk = ~clk;

  uart_tx_framer u0 (.*);

  always @(negedge clk) begin
    div  = (div == 2) ? 0 : div + 1;
    tick <= (div == 2);
  end

  always @(posedge clk) if (tick) tick_count <= tick_count + 1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(int target);
    while (tick_count < target) @(negedge clk);
  endtask

  // Sends one character and checks every bit centre and the frame length.
  task automatic frame(string req, logic [6:0] c, logic [7:0] d,
                       logic [6:0] mid_c, logic mid_dis);
    int nb, stop_t, base, k, total;
    logic slot, pv;
    logic [7:0] m;
    nb     = 5 + c[1:0];
    m      = 8'hFF >> (3 - c[1:0]);
    slot   = c[3] | c[5];
    pv     = c[5] ? c[4] : ((^(d & m)) ^ ~c[4]);
    stop_t = !c[2] ? 16 : (nb == 5 ? 24 : 32);
    total  = 16 * (1 + nb + (slot ? 1 : 0)) + stop_t;
    ctrl = c;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    base = tick_count;
    chk({req, " busy after accept R2"}, busy, 1);
    wait_tick(base + 8);
    chk({req, " start bit R2"}, txd ^ tx_invert, 0);
    ctrl = mid_c;
    tx_disable = mid_dis;
    for (int i = 0; i < nb; i++) begin
      wait_tick(base + 16 * (i + 1) + 8);
      chk({req, " data bit R2 R3"}, txd ^ tx_invert, d[i]);
    end
    k = 1 + nb;
    if (slot) begin
      wait_tick(base + 16 * k + 8);
      chk({req, " parity slot R5 R6"}, txd ^ tx_invert, pv);
      k++;
    end
    wait_tick(base + 16 * k + 8);
    chk({req, " stop level R4"}, txd ^ tx_invert, 1);
    wait_tick(base + total - 1);
    chk({req, " busy before stop end R4"}, busy, 1);
    wait_tick(base + total);
    chk({req, " idle at stop end R4"}, busy, 0);
  endtask

  task automatic t_reset;
    chk("reset busy R1", busy, 0);
    chk("reset line R1", txd, 1);
    chk("reset ready R1", in_ready, 1);
  endtask

  task automatic t_formats;
    frame("8N1", 7'b000_0011, 8'hA5, 7'b000_0011, 1'b0);
    frame("5-bit 1.5 stop", 7'b000_0100, 8'hF6, 7'b000_0100, 1'b0);
    frame("7 even 2 stop", 7'b001_1110, 8'h53, 7'b001_1110, 1'b0);
    frame("6 odd", 7'b000_1001, 8'h25, 7'b000_1001, 1'b0);
    frame("8 even zero ones", 7'b001_1011, 8'h00, 7'b001_1011, 1'b0);
  endtask

  task automatic t_force;
    frame("force mark R6", 7'b011_0011, 8'h01, 7'b011_0011, 1'b0);
    frame("force space R6", 7'b010_1011, 8'h03, 7'b010_1011, 1'b0);
  endtask

  task automatic t_invert;
    tx_invert = 1'b1;
    @(negedge clk);
    chk("idle inverted R9", txd, 0);
    frame("inverted 8N1 R9", 7'b000_0011, 8'h3C, 7'b000_0011, 1'b0);
    tx_invert = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_mid_change;
    frame("ctrl change mid-frame R10", 7'b000_0011, 8'hC3, 7'b000_1100, 1'b0);
  endtask

  task automatic t_break_idle;
    ctrl = 7'b000_0011;
    @(negedge clk);
    ctrl[6]  = 1'b1;
    in_valid = 1'b1;
    in_data  = 8'h55;
    @(negedge clk);
    chk("break refuses same-cycle char R7", busy, 0);
    chk("break line low R7", txd, 0);
    chk("break ready low R7", in_ready, 0);
    wait_tick(tick_count + 20);
    chk("break held, no start R7", busy, 0);
    in_valid = 1'b0;
    ctrl[6]  = 1'b0;
    @(negedge clk);
    chk("break released line high R7", txd, 1);
  endtask

  task automatic t_break_mid;
    frame("break mid-frame R7", 7'b000_0011, 8'h96, 7'b100_0011, 1'b0);
    in_valid = 1'b1;
    in_data  = 8'h11;
    @(negedge clk);
    chk("break after frame line low R7", txd, 0);
    chk("break after frame no start R7", busy, 0);
    in_valid = 1'b0;
    ctrl[6]  = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disable;
    frame("disable mid-frame R8", 7'b000_0011, 8'h69, 7'b000_0011, 1'b1);
    in_valid = 1'b1;
    in_data  = 8'h0F;
    wait_tick(tick_count + 40);
    chk("disabled ready low R8", in_ready, 0);
    chk("disabled no start R8", busy, 0);
    chk("disabled line idle R8", txd, 1);
    in_valid   = 1'b0;
    tx_disable = 1'b0;
    @(negedge clk);
    chk("enabled ready back R1", in_ready, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_force();
    t_invert();
    t_mid_change();
    t_break_idle();
    t_break_mid();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule